// File: doc/BRIEF.md
# Run-Time Configurable Sliding-Window Line Buffer

This block turns a raster stream of feature-map pixels into square convolution windows. Pixels arrive one per handshake, row after row, and the block keeps the most recent rows in on-chip row stores. It then presents the full window whose bottom-right corner is the pixel just accepted. Once enough rows are primed, every accepted pixel yields one window on the next clock, so a compute array behind it can take a new window on every cycle.

Two values set the shape of the window: the side length of the window and the number of pixels per row. Both are loaded at run time from two byte fields of a 64-bit instruction word, so one instance serves layers of different shapes. A synthesis-time parameter sets the largest allowed value of each. A value outside the supported range is clamped and flagged. A new word is taken only while the block is quiet, and taking it restarts the fill from an empty state.

Both streams use valid/ready. An input pixel is accepted when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` is high whenever the output slot is empty or is being emptied in the same cycle. A window that is offered and not taken stays on the output unchanged, and input stalls meanwhile, so no pixel is dropped or repeated.

Top module: `slidewin_linebuf`

## Requirements
- R1: On an applied load, the window side K is taken from `cfg_word[15:8]` and the row length D from `cfg_word[55:48]`. All other bits of the word are ignored.
- R2: Window entry (r,c) occupies `out_window[(r*K_MAX+c)*PIX_W +: PIX_W]`. Row r=0 is the oldest row and column c=0 the leftmost. For the window ending at row y and column x, entry (r,c) with r,c < K equals the pixel at (y-K+1+r, x-K+1+c). Entries with r >= K or c >= K read zero.
- R3: When a pixel is accepted, `out_valid` in the next cycle equals whether that pixel is a valid window end: its row index and column index are both at least K-1.
- R4: No window is offered before (K-1) full rows plus K pixels have been accepted, and none is offered at columns below K-1. A frame of H rows yields exactly (H-K+1)*(D-K+1) windows.
- R5: While `out_valid` is high and `out_ready` is low, the window stays valid and unchanged. `in_ready` equals `!out_valid || out_ready`. Every pixel is used exactly once.
- R6: A load strobe takes effect only in a cycle with `in_valid` low and `out_valid` low. A load strobe in any other cycle has no effect on the configuration or on `cfg_err`.
- R7: An applied load clears the row stores, the window registers and the row and column position, so the next pixel starts a fresh frame at row 0, column 0.
- R8: A requested K of 0 becomes 1, and a requested K above K_MAX becomes K_MAX. Either case sets `cfg_err`.
- R9: A requested D above D_MAX becomes D_MAX, and a D below the resulting K becomes K. Either case sets `cfg_err`. `cfg_err` holds until the next applied load.
- R10: After reset, K is K_MAX, D is D_MAX, `out_valid` and `cfg_err` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load strobe for the instruction word |
| cfg_word | input | 64 | Instruction word carrying the window side and the row length |
| in_valid | input | 1 | Input pixel is offered |
| in_ready | output | 1 | Block can accept a pixel this cycle |
| in_pixel | input | PIX_W | Input pixel value |
| out_valid | output | 1 | A complete window is offered |
| out_ready | input | 1 | Consumer takes the window this cycle |
| out_window | output | K_MAX*K_MAX*PIX_W | Window entries, row-major, active region top-left |
| cfg_err | output | 1 | Last applied load needed clamping |

## Verification
The bound checker watches the cycle-level rules on every clock: a stalled window stays put, a window only appears after an input handshake, no window shows up before the priming count for the current shape is reached, a load strobe in a busy cycle leaves the shape unchanged, the error flag only rises after a load, and the shape stays within its legal range. The correctness of window contents, the skipping of row-wrap positions, the exact window count per frame, the clamping arithmetic and the clearing of old rows by a reload can only be seen by the bench. It streams whole frames of known pixels under several shapes and stall patterns and compares every window against its own model.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
  // Byte fields of the instruction word that the decoder reads
  localparam int KSIZE_LSB = 8;
  localparam int RLEN_LSB  = 48;
  localparam int FIELD_W   = 8;
endpackage

// File: rtl/lbw_cfg_decode.sv
module lbw_cfg_decode
  import lbw_pkg::*;
#(
  parameter int K_MAX = 5,
  parameter int D_MAX = 64,
  localparam int KW = $clog2(K_MAX + 1),
  localparam int DW = $clog2(D_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [63:0]   cfg_word,
  input  logic          idle,
  output logic          apply,
  output logic [KW-1:0] k_q,
  output logic [DW-1:0] d_q,
  output logic          err_q
);
  logic [FIELD_W-1:0] raw_k, raw_d, k_n, d_n;
  logic               e_n;

  assign apply = cfg_load && idle;
  assign raw_k = cfg_word[KSIZE_LSB +: FIELD_W];
  assign raw_d = cfg_word[RLEN_LSB +: FIELD_W];

  always_comb begin
    e_n = 1'b0;
    k_n = raw_k;
    if (raw_k == '0) begin
      k_n = FIELD_W'(1);
      e_n = 1'b1;
    end else if (raw_k > FIELD_W'(K_MAX)) begin
      k_n = FIELD_W'(K_MAX);
      e_n = 1'b1;
    end
    d_n = raw_d;
    if (raw_d > FIELD_W'(D_MAX)) begin
      d_n = FIELD_W'(D_MAX);
      e_n = 1'b1;
    end
    if (d_n < k_n) begin
      d_n = k_n;
      e_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q   <= KW'(K_MAX);
      d_q   <= DW'(D_MAX);
      err_q <= 1'b0;
    end else if (apply) begin
      k_q   <= k_n[KW-1:0];
      d_q   <= d_n[DW-1:0];
      err_q <= e_n;
    end
  end
endmodule

// File: rtl/lbw_row_store.sv
module lbw_row_store #(
  parameter int PIX_W = 8,
  parameter int K_MAX = 5,
  parameter int D_MAX = 64,
  localparam int NB = K_MAX - 1,
  localparam int AW = (D_MAX > 1) ? $clog2(D_MAX) : 1,
  localparam int DW = $clog2(D_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     shift,
  input  logic [DW-1:0]            depth,
  input  logic [PIX_W-1:0]         pix_in,
  output logic [NB-1:0][PIX_W-1:0] taps
);
  logic [DW-1:0] wp, wp_nx;

  assign wp_nx = wp + DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wp <= '0;
    else if (flush) wp <= '0;
    else if (shift) wp <= (wp_nx == depth) ? '0 : wp_nx;
  end

  // Each store delays its input by one row length; the stores are chained
  for (genvar j = 0; j < NB; j++) begin : g_store
    logic [PIX_W-1:0] mem [D_MAX];
    logic [PIX_W-1:0] wdat;

    if (j == 0) begin : g_head
      assign wdat = pix_in;
    end else begin : g_link
      assign wdat = taps[j-1];
    end

    assign taps[j] = mem[wp[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int a = 0; a < D_MAX; a++) mem[a] <= '0;
      end else if (flush) begin
        for (int a = 0; a < D_MAX; a++) mem[a] <= '0;
      end else if (shift) begin
        mem[wp[AW-1:0]] <= wdat;
      end
    end
  end
endmodule

// File: rtl/lbw_fill_track.sv
module lbw_fill_track #(
  parameter int K_MAX = 5,
  parameter int D_MAX = 64,
  localparam int KW = $clog2(K_MAX + 1),
  localparam int DW = $clog2(D_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          shift,
  input  logic [KW-1:0] k,
  input  logic [DW-1:0] depth,
  output logic          win_ok
);
  logic [DW-1:0] x_q, x_nx;
  logic [KW-1:0] y_q;

  assign x_nx   = x_q + DW'(1);
  // True for the pixel now at the input: rows above and columns to the left are complete
  assign win_ok = (int'(y_q) + 1 >= int'(k)) && (int'(x_q) + 1 >= int'(k));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (flush) begin
      x_q <= '0;
      y_q <= '0;
    end else if (shift) begin
      if (x_nx == depth) begin
        x_q <= '0;
        if (int'(y_q) < K_MAX - 1) y_q <= y_q + KW'(1);
      end else begin
        x_q <= x_nx;
      end
    end
  end
endmodule

// File: rtl/lbw_window.sv
module lbw_window #(
  parameter int PIX_W = 8,
  parameter int K_MAX = 5,
  localparam int KW = $clog2(K_MAX + 1),
  localparam int IW = (K_MAX > 1) ? $clog2(K_MAX) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            shift,
  input  logic [KW-1:0]                   k,
  input  logic [PIX_W-1:0]                pix_in,
  input  logic [K_MAX-2:0][PIX_W-1:0]     taps,
  output logic [K_MAX*K_MAX*PIX_W-1:0]    win_flat
);
  logic [PIX_W-1:0]             w [K_MAX][K_MAX];
  logic [K_MAX-1:0][PIX_W-1:0]  nc;

  // New column: bottom row is the live pixel, rows above come from older row stores
  always_comb begin
    nc[K_MAX-1] = pix_in;
    for (int r = 0; r < K_MAX - 1; r++) nc[r] = taps[K_MAX-2-r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < K_MAX; r++)
        for (int c = 0; c < K_MAX; c++) w[r][c] <= '0;
    end else if (flush) begin
      for (int r = 0; r < K_MAX; r++)
        for (int c = 0; c < K_MAX; c++) w[r][c] <= '0;
    end else if (shift) begin
      for (int r = 0; r < K_MAX; r++) begin
        for (int c = 0; c < K_MAX - 1; c++) w[r][c] <= w[r][c+1];
        w[r][K_MAX-1] <= nc[r];
      end
    end
  end

  // The active K x K region sits in the bottom-right corner of w; move it to top-left
  always_comb begin
    win_flat = '0;
    for (int r = 0; r < K_MAX; r++) begin
      for (int c = 0; c < K_MAX; c++) begin
        int ri, ci;
        ri = r + K_MAX - int'(k);
        ci = c + K_MAX - int'(k);
        if (r < int'(k) && c < int'(k))
          win_flat[(r*K_MAX+c)*PIX_W +: PIX_W] = w[ri[IW-1:0]][ci[IW-1:0]];
      end
    end
  end
endmodule

// File: rtl/slidewin_linebuf.sv
module slidewin_linebuf #(
  parameter int PIX_W = 8,
  parameter int K_MAX = 5,
  parameter int D_MAX = 64,
  localparam int KW = $clog2(K_MAX + 1),
  localparam int DW = $clog2(D_MAX + 1),
  localparam int WIN_W = K_MAX * K_MAX * PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [63:0]      cfg_word,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIN_W-1:0] out_window,
  output logic             cfg_err
);
  logic                        idle, cfg_apply, accept, win_ok;
  logic [KW-1:0]               cur_k;
  logic [DW-1:0]               cur_d;
  logic [K_MAX-2:0][PIX_W-1:0] taps;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign idle     = !in_valid && !out_valid;

  lbw_cfg_decode #(.K_MAX(K_MAX), .D_MAX(D_MAX)) u_dec (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .idle(idle), .apply(cfg_apply), .k_q(cur_k), .d_q(cur_d), .err_q(cfg_err)
  );

  lbw_row_store #(.PIX_W(PIX_W), .K_MAX(K_MAX), .D_MAX(D_MAX)) u_rows (
    .clk(clk), .rst_n(rst_n), .flush(cfg_apply), .shift(accept),
    .depth(cur_d), .pix_in(in_pixel), .taps(taps)
  );

  lbw_fill_track #(.K_MAX(K_MAX), .D_MAX(D_MAX)) u_fill (
    .clk(clk), .rst_n(rst_n), .flush(cfg_apply), .shift(accept),
    .k(cur_k), .depth(cur_d), .win_ok(win_ok)
  );

  lbw_window #(.PIX_W(PIX_W), .K_MAX(K_MAX)) u_win (
    .clk(clk), .rst_n(rst_n), .flush(cfg_apply), .shift(accept),
    .k(cur_k), .pix_in(in_pixel), .taps(taps), .win_flat(out_window)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          out_valid <= 1'b0;
    else if (cfg_apply)  out_valid <= 1'b0;
    else if (accept)     out_valid <= win_ok;
    else if (out_ready)  out_valid <= 1'b0;
  end
endmodule

// File: rtl/lbw_checker.sv
module lbw_checker #(
  parameter int PIX_W = 8,
  parameter int K_MAX = 5,
  parameter int D_MAX = 64,
  localparam int KW = $clog2(K_MAX + 1),
  localparam int DW = $clog2(D_MAX + 1),
  localparam int WIN_W = K_MAX * K_MAX * PIX_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             cfg_apply,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIN_W-1:0] out_window,
  input logic             cfg_err,
  input logic [KW-1:0]    k,
  input logic [DW-1:0]    d
);
  logic [15:0] acc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             acc_cnt <= '0;
    else if (cfg_apply)                     acc_cnt <= '0;
    else if (in_valid && in_ready && acc_cnt != 16'hFFFF) acc_cnt <= acc_cnt + 16'd1;
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_window));

  p_rise_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  p_primed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(acc_cnt) >= (int'(k) - 1) * int'(d) + int'(k));

  p_busy_load_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && (in_valid || out_valid) |=> $stable(k) && $stable(d) && $stable(cfg_err));

  p_err_from_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cfg_load));

  p_shape_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    k >= KW'(1) && int'(k) <= K_MAX && int'(d) >= int'(k) && int'(d) <= D_MAX);
endmodule

bind slidewin_linebuf lbw_checker #(.PIX_W(PIX_W), .K_MAX(K_MAX), .D_MAX(D_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_apply(cfg_apply),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_window(out_window), .cfg_err(cfg_err),
  .k(cur_k), .d(cur_d)
);

// File: tb/slidewin_linebuf_tb_top.sv
module slidewin_linebuf_tb_top;
  localparam int PW = 8;
  localparam int KM = 5;
  localparam int DM = 64;
  localparam int WW = KM * KM * PW;

  // {k_req, d_req, rows, mode, k_exp, d_exp, err_exp}, one byte each
  localparam logic [55:0] VEC [9] = '{
    56'h03_08_05_00_03_08_00,
    56'h05_0A_06_01_05_0A_00,
    56'h01_04_02_00_01_04_00,
    56'h02_06_04_02_02_06_00,
    56'h04_04_05_01_04_04_00,
    56'h09_0C_06_00_05_0C_01,
    56'h03_C8_04_02_03_40_01,
    56'h00_05_02_00_01_05_01,
    56'h04_02_05_00_04_04_01
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_load;
  logic [63:0]   cfg_word;
  logic          in_valid, in_ready, out_valid, out_ready, cfg_err;
  logic [PW-1:0] in_pixel;
  logic [WW-1:0] out_window;

  always #2 clk = ~clk;

  slidewin_linebuf #(.PIX_W(PW), .K_MAX(KM), .D_MAX(DM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_ready(out_ready), .out_window(out_window),
    .cfg_err(cfg_err)
  );

  int n_run  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pixv(input int seed, input int y, input int x);
    return PW'((seed * 31 + y * 17 + x * 5 + 1) & 255);
  endfunction

  task automatic apply_cfg(input int kin, input int din, input int eerr, input string tag);
    @(negedge clk);
    cfg_word        = 64'hF0E1_D2C3_B4A5_9687;
    cfg_word[15:8]  = 8'(kin);
    cfg_word[55:48] = 8'(din);
    cfg_load  = 1'b1;
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    chk(cfg_err == 1'(eerr), tag, "cfg_err after load", int'(cfg_err), eerr);
  endtask

  task automatic run_frame(input int ek, input int ed, input int rows, input int mode,
                           input int seed, input bit probe, input string ctag);
    int total, nw, p, widx, cyc, bad3, bad5, held;
    bit prev_acc, prev_elig, hold_pend, probe2_done, iv, rd;
    logic [WW-1:0] hold_win;
    total = rows * ed;
    nw = (rows - ek + 1) * (ed - ek + 1);
    p = 0; widx = 0; cyc = 0; bad3 = 0; bad5 = 0; held = 0;
    prev_acc = 0; prev_elig = 0; hold_pend = 0; probe2_done = 0;
    hold_win = '0;
    while ((p < total || widx < nw) && cyc < 20000) begin
      @(negedge clk);
      if (prev_acc && (out_valid !== prev_elig)) bad3++;
      if (hold_pend) begin
        held++;
        if (!out_valid || out_window !== hold_win) bad5++;
      end
      cfg_load = 1'b0;
      case (mode)
        1:       begin iv = 1'b1; rd = cyc[0]; end
        2:       begin iv = (cyc % 3) != 2; rd = (cyc % 4) != 3; end
        default: begin iv = 1'b1; rd = 1'b1; end
      endcase
      in_valid  = (p < total) && iv;
      in_pixel  = (p < total) ? pixv(seed, p / ed, p % ed) : '0;
      out_ready = rd;
      if (probe && cyc == 3) begin
        cfg_word = 64'h0;          // illegal shape, offered while a pixel is offered
        cfg_load = 1'b1;
      end
      if (probe && out_valid && !probe2_done) begin
        probe2_done = 1'b1;
        cfg_word  = 64'h0;         // illegal shape, offered while a window waits
        cfg_load  = 1'b1;
        in_valid  = 1'b0;
        out_ready = 1'b0;
      end
      #1;
      hold_pend = out_valid && !out_ready;
      hold_win  = out_window;
      if (out_valid && out_ready) begin
        if (widx >= nw) begin
          chk(1'b0, "R4", "window beyond expected count", widx + 1, nw);
        end else begin
          int wy, wx, mism, a_v, e_v;
          wy = ek - 1 + widx / (ed - ek + 1);
          wx = ek - 1 + widx % (ed - ek + 1);
          mism = 0; a_v = 0; e_v = 0;
          for (int r = 0; r < KM; r++) begin
            for (int c = 0; c < KM; c++) begin
              logic [PW-1:0] ev, av;
              ev = (r < ek && c < ek) ? pixv(seed, wy - ek + 1 + r, wx - ek + 1 + c) : '0;
              av = out_window[(r*KM+c)*PW +: PW];
              if (av !== ev && mism == 0) begin a_v = int'(av); e_v = int'(ev); end
              if (av !== ev) mism++;
            end
          end
          chk(mism == 0, "R2", $sformatf("window %0d at y=%0d x=%0d", widx, wy, wx), a_v, e_v);
        end
        widx++;
      end
      prev_acc  = in_valid && in_ready;
      prev_elig = prev_acc && (p / ed >= ek - 1) && (p % ed >= ek - 1);
      if (prev_acc) p++;
      cyc++;
    end
    @(negedge clk);
    cfg_load  = 1'b0;
    in_valid  = 1'b0;
    out_ready = 1'b1;
    chk(p == total && widx == nw, ctag, "windows per frame", widx, nw);
    chk(bad3 == 0, "R3", "out_valid after accept", bad3, 0);
    if (held > 0) chk(bad5 == 0, "R5", "stalled window held", bad5, 0);
    chk(out_valid == 1'b0, "R4", "no trailing window", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_word = '0;
    in_valid = 1'b0; in_pixel = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R10", "in_ready after reset", int'(in_ready), 1);
    chk(cfg_err == 1'b0, "R10", "cfg_err after reset", int'(cfg_err), 0);

    // Default shape after reset: K_MAX by K_MAX over rows of D_MAX
    run_frame(KM, DM, KM, 0, 7, 1'b0, "R10");

    // Table of shapes and stall patterns
    for (int i = 0; i < 9; i++) begin
      int kin, din, rows, mode, ek, ed, eerr;
      kin  = int'(VEC[i][55:48]);
      din  = int'(VEC[i][47:40]);
      rows = int'(VEC[i][39:32]);
      mode = int'(VEC[i][31:24]);
      ek   = int'(VEC[i][23:16]);
      ed   = int'(VEC[i][15:8]);
      eerr = int'(VEC[i][7:0]);
      if (eerr != 0 && kin != ek) apply_cfg(kin, din, eerr, "R8");
      else if (eerr != 0)         apply_cfg(kin, din, eerr, "R9");
      else                        apply_cfg(kin, din, eerr, "R1");
      run_frame(ek, ed, rows, mode, i + 3, 1'b0, "R4");
    end

    // Load strobes in busy cycles must be ignored
    apply_cfg(3, 4, 0, "R1");
    run_frame(3, 4, 5, 0, 11, 1'b1, "R6");
    chk(cfg_err == 1'b0, "R6", "cfg_err after busy loads", int'(cfg_err), 0);

    // Partial frame, then a reload must discard everything held
    apply_cfg(3, 6, 0, "R1");
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_pixel  = 8'hEE;
      out_ready = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    apply_cfg(3, 6, 0, "R7");
    run_frame(3, 6, 4, 0, 23, 1'b0, "R7");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule